// File: doc/BRIEF.md
# Cycle-Count Frequency Meter

This block measures how fast a slow or free-running clock runs by counting reference-clock cycles across a window of that clock's own rising edges. The measured signal enters as an asynchronous level toggle. A two-flop synchronizer brings it into the reference domain, and a rising-edge detector turns it into one-cycle pulses. A separate gate input must be high, otherwise the toggle never reaches the synchronizer. Software writes a control word that holds the window length and the detector enable. It then waits for the done flag and reads the count.

A measurement starts when the enable rises. At that point the result and the done flag clear, and the window length is captured. While the measurement runs, every reference cycle increments a saturating counter. Once the captured number of measured rising edges has arrived, the counter value is frozen into the result and the done flag sets. The flag stays set until the enable is cleared.

The result and the done flag are register outputs that hold their value for as long as software needs it. For that reason there is no valid/ready handshake and no back-pressure. A result of zero, or a saturated result, is a legal outcome that the consumer must handle. A typical calibration window is 1024 edges.

Top module: `cyc_freq_meter`

## Requirements
- R1: While reset is asserted, and right after it, `result` is 0 and `meas_done` is 0.
- R2: `ctrl_word[23:0]` is the window length and `ctrl_word[24]` is the detector enable. On the first clock edge that samples the enable high after it was low, `result` and `meas_done` clear and the window length is captured.
- R3: `meas_tgl` passes through two synchronizer flops and a rising-edge detector. The detector fires on the second clock edge after the edge that first samples the new high level, and only low-to-high transitions are counted.
- R4: Take the clock edges after the starting edge, up to and including the edge that counts the last window edge. `result` equals the number of those edges, and `meas_done` sets on that same edge.
- R5: While the enable stays high, `meas_done` remains set and `result` does not change once a measurement completes.
- R6: One clock edge after the enable is sampled low, `meas_done` is 0.
- R7: While `frun_en` is low, the measured toggle is blocked and no measurement completes.
- R8: A captured window length of 0 never sets `meas_done`.
- R9: The cycle counter stops at all-ones (2^CNT_W-1) and does not wrap, so `result` can be all-ones.
- R10: Changes to `ctrl_word[23:0]` while a measurement is running do not affect it, because only the captured length is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 25 | [23:0] window length in measured edges, [24] detector enable |
| frun_en | input | 1 | Gate that lets the measured toggle reach the synchronizer |
| meas_tgl | input | 1 | Asynchronous measured clock level |
| result | output | CNT_W (32) | Reference-cycle count of the last completed measurement |
| meas_done | output | 1 | Sticky completion flag |

## Verification
The timing of each output follows from the registers between input and output.
- A level change on `meas_tgl` is counted on the third clock edge that samples it: two synchronizer flops, then one edge-detect flop.
- A completed window shows on `result` and `meas_done` right after the edge that counts its final edge.
- An enable rise or fall shows on the outputs one edge later.

The bench drives every input shortly after the falling clock edge. Its reference model steps on each rising edge from the same inputs, and every falling edge compares the model's result and done flag against the block's outputs. The named checks are taken at the same falling edges.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    FM_IDLE = 2'd0,
    FM_RUN  = 2'd1,
    FM_DONE = 2'd2
  } fm_state_e;
endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic gate,
  output logic rise_pulse
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= async_in & gate;
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= stage_q[SYNC_STAGES-1];
  end

  assign rise_pulse = stage_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/fm_window_ctrl.sv
module fm_window_ctrl
  import fm_pkg::*;
#(
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic [WIN_W-1:0] win_len,
  input  logic             edge_pulse,
  output logic             start,
  output logic             counting,
  output logic             finish,
  output logic             done,
  output logic [WIN_W-1:0] win_lat
);
  fm_state_e        state_q;
  logic             en_q;
  logic [WIN_W-1:0] edges_q;
  logic [WIN_W:0]   edges_nxt;

  assign start     = det_en & ~en_q;
  assign counting  = det_en & ~start & (state_q == FM_RUN);
  assign edges_nxt = {1'b0, edges_q} + 1'b1;
  assign finish    = counting & edge_pulse & (edges_nxt == {1'b0, win_lat});
  assign done      = (state_q == FM_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      state_q <= FM_IDLE;
      edges_q <= '0;
      win_lat <= '0;
    end else begin
      en_q <= det_en;
      if (!det_en) begin
        state_q <= FM_IDLE;
      end else if (start) begin
        edges_q <= '0;
        win_lat <= win_len;
        state_q <= (win_len != '0) ? FM_RUN : FM_IDLE;
      end else if (counting && edge_pulse) begin
        edges_q <= edges_nxt[WIN_W-1:0];
        if (finish) state_q <= FM_DONE;
      end
    end
  end
endmodule

// File: rtl/fm_sat_counter.sv
module fm_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             capture,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = (cnt_q == TOP) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      value <= '0;
    end else if (clear) begin
      cnt_q <= '0;
      value <= '0;
    end else if (run) begin
      cnt_q <= cnt_nxt;
      if (capture) value <= cnt_nxt;
    end
  end
endmodule

// File: rtl/cyc_freq_meter.sv
module cyc_freq_meter #(
  parameter int WIN_W       = 24,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W:0]   ctrl_word,
  input  logic             frun_en,
  input  logic             meas_tgl,
  output logic [CNT_W-1:0] result,
  output logic             meas_done
);
  localparam int EN_POS = WIN_W;

  logic             edge_pulse;
  logic             start;
  logic             counting;
  logic             finish;
  logic [WIN_W-1:0] win_lat;

  fm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (meas_tgl),
    .gate      (frun_en),
    .rise_pulse(edge_pulse)
  );

  fm_window_ctrl #(.WIN_W(WIN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .det_en    (ctrl_word[EN_POS]),
    .win_len   (ctrl_word[WIN_W-1:0]),
    .edge_pulse(edge_pulse),
    .start     (start),
    .counting  (counting),
    .finish    (finish),
    .done      (meas_done),
    .win_lat   (win_lat)
  );

  fm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .run    (counting),
    .capture(finish),
    .value  (result)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int WIN_W = 24,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIN_W:0]   ctrl_word,
  input logic             frun_en,
  input logic [CNT_W-1:0] result,
  input logic             meas_done,
  input logic [WIN_W-1:0] win_lat
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[WIN_W]) |=> (!meas_done && result == '0));

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_word[WIN_W]) |-> !meas_done);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && ctrl_word[WIN_W]) |=> (meas_done && $stable(result)));

  // R8
  zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_done) |-> (win_lat != '0));

  // R7
  gate_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_done) |-> $past(frun_en, 3));
endmodule

bind cyc_freq_meter fm_checker #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_word(ctrl_word),
  .frun_en  (frun_en),
  .result   (result),
  .meas_done(meas_done),
  .win_lat  (win_lat)
);

// File: tb/cyc_freq_meter_tb.sv
`timescale 1ns/1ps
module cyc_freq_meter_tb;
  localparam int WIN_W = 24;
  localparam int CNT_W = 10;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIN_W:0]   ctrl_word = '0;
  logic             frun_en = 1'b0;
  logic             meas_tgl = 1'b0;
  logic [CNT_W-1:0] result;
  logic             meas_done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int half   = 0;
  int hcnt   = 0;
  logic tgl_lvl = 1'b0;
  bit   cmp_on = 1'b0;
  bit   finished = 1'b0;

  // reference model state
  bit   hist[$];
  bit   m_en_prev = 0;
  bit   m_active = 0;
  bit   m_valid = 0;
  int   m_cnt = 0;
  int   m_edges = 0;
  int   m_win = 0;
  int   m_result = 0;

  always #5 clk = ~clk;

  cyc_freq_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .frun_en(frun_en),
    .meas_tgl(meas_tgl), .result(result), .meas_done(meas_done)
  );

  // toggle generator: half-period in clocks, or hold tgl_lvl when 0
  always @(negedge clk) begin
    if (half == 0) begin
      meas_tgl <= tgl_lvl;
      hcnt <= 0;
    end else if (hcnt + 1 >= half) begin
      meas_tgl <= ~meas_tgl;
      hcnt <= 0;
    end else begin
      hcnt <= hcnt + 1;
    end
  end

  // behavioural model, stepped on each rising edge
  always @(posedge clk) begin
    bit en;
    bit edge_seen;
    int win;
    en  = ctrl_word[WIN_W];
    win = int'(ctrl_word[WIN_W-1:0]);
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_en_prev = 0; m_active = 0; m_valid = 0;
      m_cnt = 0; m_edges = 0; m_win = 0; m_result = 0;
    end else begin
      edge_seen = hist[1] && !hist[0];
      hist.push_back(meas_tgl & frun_en);
      void'(hist.pop_front());
      if (!en) begin
        m_active = 0; m_valid = 0;
      end else if (!m_en_prev) begin
        m_result = 0; m_valid = 0; m_cnt = 0; m_edges = 0;
        m_win = win; m_active = (win != 0);
      end else if (m_active) begin
        if (m_cnt < MAXV) m_cnt++;
        if (edge_seen) begin
          m_edges++;
          if (m_edges == m_win) begin
            m_result = m_cnt; m_valid = 1; m_active = 0;
          end
        end
      end
      m_en_prev = en;
    end
  end

  // per-cycle comparison against the model (R4, R3)
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      checks++;
      if (result !== m_result[CNT_W-1:0] || meas_done !== m_valid) begin
        errors++;
        $display("FAIL R4 model cycle %0d: result=%0d done=%0b expected result=%0d done=%0b",
                 cycles, result, meas_done, m_result, m_valid);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_ctrl(input bit en, input int win);
    ctrl_word = {en, win[WIN_W-1:0]};
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      summary();
    end
  end

  initial begin
    wait_n(4);
    check("R1 result in reset", int'(result), 0);
    check("R1 done in reset", int'(meas_done), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_n(2);
    check("R1 done after reset", int'(meas_done), 0);

    // R3/R4: slow toggle, window of 4 edges
    frun_en = 1'b1; half = 4;
    set_ctrl(1, 4);
    wait_n(60);
    check("R4 done after window", int'(meas_done), 1);
    check("R4 result vs model", int'(result), m_result);
    // R5: sticky and held
    wait_n(20);
    check("R5 done held", int'(meas_done), 1);
    check("R5 result held", int'(result), m_result);

    // R6: disable drops valid
    set_ctrl(0, 4);
    wait_n(1);
    check("R6 done after disable", int'(meas_done), 0);

    // R2: restart clears, fast toggle
    half = 1;
    wait_n(2);
    set_ctrl(1, 6);
    wait_n(1);
    check("R2 result cleared on start", int'(result), 0);
    check("R2 done cleared on start", int'(meas_done), 0);
    wait_n(40);
    check("R3 fast toggle done", int'(meas_done), 1);
    check("R3 fast toggle result", int'(result), m_result);

    // R10: window change mid-run ignored
    set_ctrl(0, 0);
    wait_n(2);
    set_ctrl(1, 3);
    wait_n(2);
    set_ctrl(1, 200);
    wait_n(40);
    check("R10 captured window used", int'(meas_done), 1);

    // R7: gate low blocks measurement
    set_ctrl(0, 0);
    frun_en = 1'b0;
    wait_n(2);
    set_ctrl(1, 2);
    wait_n(100);
    check("R7 no completion with gate low", int'(meas_done), 0);

    // R8: window zero never completes
    frun_en = 1'b1;
    set_ctrl(0, 0);
    wait_n(2);
    set_ctrl(1, 0);
    wait_n(100);
    check("R8 zero window", int'(meas_done), 0);

    // R9: saturation with one very late edge
    set_ctrl(0, 0);
    half = 0; tgl_lvl = 1'b0;
    wait_n(6);
    set_ctrl(1, 1);
    wait_n(1200);
    tgl_lvl = 1'b1;
    wait_n(10);
    check("R9 done after late edge", int'(meas_done), 1);
    check("R9 saturated result", int'(result), MAXV);

    // long window below saturation
    set_ctrl(0, 0);
    tgl_lvl = 1'b0;
    half = 1;
    wait_n(4);
    set_ctrl(1, 300);
    wait_n(700);
    check("R4 long window done", int'(meas_done), 1);
    check("R4 long window result", int'(result), m_result);

    summary();
  end
endmodule